// File: doc/BRIEF.md
# Configurable Synchronous Burst Read Engine

This block is the read side of a 32-bit nonvolatile memory that answers either plain asynchronous reads or clocked burst reads. A 16-bit configuration word chooses the read mode, the number of clocks from address capture to the first data word, whether the wait indicator drops together with the first word or one cycle before it, and the burst length. A read begins when the address strobe `adv_n` and the chip enable `ce_n` are both low at a rising clock edge. In burst mode the engine counts the programmed latency and then emits one word per clock, in linear order wrapping inside the aligned group of burst-length words. In asynchronous mode, or when any field holds a reserved code, the engine drives the word at the captured address and holds it for as long as the chip stays enabled.

The array is a computed model and needs no storage. The 16-bit address chunks of the word address are XORed together into a value f, and data lane k (16 bits) holds f XOR (0x5A5A times k, kept to 16 bits). For the default 32-bit width the word is {f ^ 0x5A5A, f}. The sequencer has four states. IDLE drives nothing. ASYNC drives the captured word. LAT counts the latency. BURST drives the sequence. From IDLE or ASYNC, a strobe moves the engine to LAT when burst reads are allowed and to ASYNC otherwise. LAT moves to BURST after its last latency cycle. BURST returns to IDLE after its last word. From every state, a high `ce_n` at an edge returns the engine to IDLE.

Top module: `burst_read_engine`

## Requirements
- R1: After reset the configuration reads 0x9CC3: asynchronous mode (bit 15 = 1), latency code 7 in bits 12..10, bit 9 = 0, bit 8 = 0, bits 7 and 6 = 1, length code 3 in bits 2..0. `dq_oe` and `wait_o` are low.
- R2: A write with `cfg_we` high at an edge stores `cfg_wdata` AND 0xBFC7. Bits 14 and 5..3 always read 0. Every other bit reads back as written from the next cycle.
- R3: A strobe starts a burst only when bit 15 = 0, bit 13 = 0, bit 9 = 0, bit 7 = 1, bit 6 = 1 and the length code in bits 2..0 is 1, 2 or 3. Any other setting makes the strobe an asynchronous read.
- R4: With latency code n in bits 12..10 (bit 13 = 0), the first burst word is driven in the cycle after the (n+2)-th rising edge that follows the strobe edge. `dq_oe` stays low before that cycle.
- R5: Length codes 1, 2 and 3 give bursts of 2, 4 and 8 words, one word per clock. In the cycle after the last word, `dq_oe` is low.
- R6: Burst word i comes from address (A with its low log2(N) bits cleared) OR ((A+i) mod N), where A is the strobed address and N is the burst length.
- R7: With bit 8 = 0, `wait_o` is high in every latency cycle. With bit 8 = 1, it is high in every latency cycle except the last. `wait_o` is low at all other times.
- R8: An asynchronous read drives the word at the strobed address from the cycle after the strobe edge, and holds it while `ce_n` stays low. A new strobe in that state captures a new address.
- R9: If `ce_n` is high at an edge, the next cycle has `dq_oe` = 0 and `wait_o` = 0, and any burst or latency count in progress is abandoned.
- R10: A strobe during the latency count or during a burst has no effect on that access.
- R11: The word at address a is built by lanes from the folded value f, as described above. `dq_out` is 0 whenever `dq_oe` is low.
- R12: The configuration is captured at the strobe edge. A register write during a latency count or a burst changes neither that access's length, its latency nor its wait timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all activity on the rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write enable |
| cfg_wdata | input | 16 | Configuration write value |
| cfg_rdata | output | 16 | Current configuration value |
| ce_n | input | 1 | Active-low chip enable |
| adv_n | input | 1 | Active-low address strobe |
| addr | input | ADDR_W (20) | Word address captured at the strobe |
| dq_out | output | DATA_W (32) | Read data, zero when not driven |
| dq_oe | output | 1 | High when `dq_out` carries valid data |
| wait_o | output | 1 | Latency indicator, high while the first word is pending |

## Verification
The bench aims at the first-word cycle for each of the eight latency codes. An off-by-one in the latency counter would shift every burst by a cycle, and the per-cycle comparison catches that at once. It runs every length code, including the reserved ones, and starts bursts at unaligned addresses. A design that did not wrap would run past the aligned group. A design that ignored the reserved codes would start a burst where a held asynchronous word is due. The early-wait setting is tried at the shortest and longest latencies, where an off-by-one would either leave the indicator high on the first data cycle or drop it on the strobe cycle. Chip-enable aborts, stray strobes and configuration writes in the middle of an access check that an access is never restarted and never picks up a new length.

// File: rtl/brd_pkg.sv
package brd_pkg;

    localparam int CFG_W        = 16;
    localparam int LAT_W        = 3;
    localparam int LEN_W        = 2;
    localparam int MAX_LEN_LOG2 = 3;
    localparam int CNT_W        = LAT_W + 1;
    localparam int BEAT_W       = MAX_LEN_LOG2;
    localparam int LANE_W       = 16;

    // bits 14 and 5..3 are forced to zero on every write
    localparam logic [CFG_W-1:0] CFG_KEEP = 16'hBFC7;
    // async, latency code 7, wait during delay, linear, rising edge, 8 words
    localparam logic [CFG_W-1:0] CFG_RST  = 16'h9CC3;

    localparam int B_MODE   = 15;
    localparam int B_LATHI  = 13;
    localparam int B_HOLD   = 9;
    localparam int B_EARLY  = 8;
    localparam int B_ORDER  = 7;
    localparam int B_EDGE   = 6;

    localparam logic [LANE_W-1:0] LANE_SALT = 16'h5A5A;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_ASYNC,
        ST_LAT,
        ST_BURST
    } seq_state_t;

    typedef struct packed {
        logic             sync_ok;
        logic [LAT_W-1:0] lat;
        logic [LEN_W-1:0] len;
        logic             early;
    } rd_cfg_t;

endpackage

// File: rtl/brd_cfg_reg.sv
module brd_cfg_reg
    import brd_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [CFG_W-1:0] wdata,
    output logic [CFG_W-1:0] q,
    output rd_cfg_t          fields
);

    logic [CFG_W-1:0] reg_q;
    logic             len_ok;
    logic             fixed_ok;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            reg_q <= CFG_RST;
        end else if (we) begin
            reg_q <= wdata & CFG_KEEP;
        end
    end

    always_comb begin
        unique case (reg_q[2:0])
            3'b001, 3'b010, 3'b011: len_ok = 1'b1;
            default:                len_ok = 1'b0;
        endcase
        fixed_ok       = reg_q[B_ORDER] && reg_q[B_EDGE] && !reg_q[B_HOLD];
        fields.sync_ok = !reg_q[B_MODE] && !reg_q[B_LATHI] && fixed_ok && len_ok;
        fields.lat     = reg_q[B_LATHI-1 -: LAT_W];
        fields.len     = reg_q[LEN_W-1:0];
        fields.early   = reg_q[B_EARLY];
    end

    assign q = reg_q;

endmodule

// File: rtl/brd_array_model.sv
module brd_array_model
    import brd_pkg::*;
#(
    parameter int ADDR_W = 20,
    parameter int DATA_W = 32
) (
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] word
);

    localparam int CHUNKS = (ADDR_W + LANE_W - 1) / LANE_W;
    localparam int EXT_W  = CHUNKS * LANE_W;
    localparam int LANES  = DATA_W / LANE_W;

    logic [EXT_W-1:0]  addr_ext;
    logic [LANE_W-1:0] folded;

    always_comb begin
        addr_ext = EXT_W'(rd_addr);
        folded   = '0;
        for (int c = 0; c < CHUNKS; c++) begin
            folded = folded ^ addr_ext[c*LANE_W +: LANE_W];
        end
    end

    for (genvar k = 0; k < LANES; k++) begin : g_lane
        localparam logic [LANE_W-1:0] SALT = LANE_W'(LANE_SALT * k);
        assign word[k*LANE_W +: LANE_W] = folded ^ SALT;
    end

endmodule

// File: rtl/brd_burst_seq.sv
module brd_burst_seq
    import brd_pkg::*;
#(
    parameter int ADDR_W = 20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ce_n,
    input  logic              adv_n,
    input  logic [ADDR_W-1:0] addr,
    input  rd_cfg_t           cfg,
    output logic [ADDR_W-1:0] rd_addr,
    output logic              dq_oe,
    output logic              wait_o,
    output logic              in_burst
);

    seq_state_t        state_q, state_n;
    logic [ADDR_W-1:0] base_q, base_n;
    logic [CNT_W-1:0]  cnt_q, cnt_n;
    logic [BEAT_W-1:0] beat_q, beat_n;
    logic [BEAT_W-1:0] last_q, last_n;
    logic              early_q, early_n;
    logic              strobe;
    logic [ADDR_W-1:0] wrap_mask;
    logic [ADDR_W-1:0] wrap_addr;

    assign strobe = !ce_n && !adv_n;

    // next-state and capture logic
    always_comb begin
        state_n = state_q;
        base_n  = base_q;
        cnt_n   = cnt_q;
        beat_n  = beat_q;
        last_n  = last_q;
        early_n = early_q;
        if (ce_n) begin
            state_n = ST_IDLE;
        end else begin
            unique case (state_q)
                ST_IDLE, ST_ASYNC: begin
                    if (strobe) begin
                        base_n = addr;
                        if (cfg.sync_ok) begin
                            state_n = ST_LAT;
                            cnt_n   = CNT_W'(cfg.lat) + CNT_W'(1);
                            beat_n  = '0;
                            last_n  = BEAT_W'((1 << cfg.len) - 1);
                            early_n = cfg.early;
                        end else begin
                            state_n = ST_ASYNC;
                        end
                    end
                end
                ST_LAT: begin
                    if (cnt_q == '0) begin
                        state_n = ST_BURST;
                    end else begin
                        cnt_n = cnt_q - CNT_W'(1);
                    end
                end
                ST_BURST: begin
                    if (beat_q == last_q) begin
                        state_n = ST_IDLE;
                    end else begin
                        beat_n = beat_q + BEAT_W'(1);
                    end
                end
                default: state_n = ST_IDLE;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            base_q  <= '0;
            cnt_q   <= '0;
            beat_q  <= '0;
            last_q  <= '0;
            early_q <= 1'b0;
        end else begin
            state_q <= state_n;
            base_q  <= base_n;
            cnt_q   <= cnt_n;
            beat_q  <= beat_n;
            last_q  <= last_n;
            early_q <= early_n;
        end
    end

    assign wrap_mask = ADDR_W'(last_q);
    assign wrap_addr = (base_q & ~wrap_mask) | ((base_q + ADDR_W'(beat_q)) & wrap_mask);

    // outputs decoded from state
    always_comb begin
        dq_oe    = 1'b0;
        wait_o   = 1'b0;
        in_burst = 1'b0;
        rd_addr  = base_q;
        unique case (state_q)
            ST_IDLE: begin
                dq_oe = 1'b0;
            end
            ST_ASYNC: begin
                dq_oe = 1'b1;
            end
            ST_LAT: begin
                wait_o = early_q ? (cnt_q != '0) : 1'b1;
            end
            ST_BURST: begin
                dq_oe    = 1'b1;
                in_burst = 1'b1;
                rd_addr  = wrap_addr;
            end
            default: dq_oe = 1'b0;
        endcase
    end

endmodule

// File: rtl/burst_read_engine.sv
module burst_read_engine
    import brd_pkg::*;
#(
    parameter int ADDR_W = 20,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [15:0]       cfg_wdata,
    output logic [15:0]       cfg_rdata,
    input  logic              ce_n,
    input  logic              adv_n,
    input  logic [ADDR_W-1:0] addr,
    output logic [DATA_W-1:0] dq_out,
    output logic              dq_oe,
    output logic              wait_o
);

    rd_cfg_t           fields;
    logic [ADDR_W-1:0] rd_addr;
    logic [DATA_W-1:0] word;
    logic              in_burst;

    brd_cfg_reg u_cfg (
        .clk    (clk),
        .rst_n  (rst_n),
        .we     (cfg_we),
        .wdata  (cfg_wdata),
        .q      (cfg_rdata),
        .fields (fields)
    );

    brd_burst_seq #(.ADDR_W(ADDR_W)) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .ce_n     (ce_n),
        .adv_n    (adv_n),
        .addr     (addr),
        .cfg      (fields),
        .rd_addr  (rd_addr),
        .dq_oe    (dq_oe),
        .wait_o   (wait_o),
        .in_burst (in_burst)
    );

    brd_array_model #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_array (
        .rd_addr (rd_addr),
        .word    (word)
    );

    assign dq_out = dq_oe ? word : '0;

endmodule

// File: rtl/brd_chk.sv
module brd_chk
    import brd_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cfg_we,
    input logic [15:0]       cfg_wdata,
    input logic [15:0]       cfg_rdata,
    input logic              ce_n,
    input logic              adv_n,
    input logic [DATA_W-1:0] dq_out,
    input logic              dq_oe,
    input logic              wait_o,
    input logic              in_burst
);

    assert_reserved_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_rdata[14] == 1'b0) && (cfg_rdata[5:3] == 3'b000));

    assert_cfg_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(cfg_we) && $past(rst_n)) |-> (cfg_rdata == ($past(cfg_wdata) & CFG_KEEP)));

    assert_abort_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ce_n |=> (!dq_oe && !wait_o));

    assert_wait_data_exclusive_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !(wait_o && dq_oe));

    assert_wait_rise_on_strobe_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wait_o) |-> $past(!adv_n && !ce_n));

    assert_burst_advances_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (in_burst && $past(in_burst) && $past(rst_n)) |-> (dq_out != $past(dq_out)));

    assert_idle_zero_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !dq_oe |-> (dq_out == '0));

endmodule

bind burst_read_engine brd_chk #(.DATA_W(DATA_W)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_we    (cfg_we),
    .cfg_wdata (cfg_wdata),
    .cfg_rdata (cfg_rdata),
    .ce_n      (ce_n),
    .adv_n     (adv_n),
    .dq_out    (dq_out),
    .dq_oe     (dq_oe),
    .wait_o    (wait_o),
    .in_burst  (in_burst)
);

// File: tb/burst_read_engine_tb_top.sv
`timescale 1ns/1ps
module burst_read_engine_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [15:0] cfg_wdata = 16'h0000;
    logic        ce_n = 1'b1;
    logic        adv_n = 1'b1;
    logic [19:0] addr = 20'h0;
    logic [15:0] cfg_rdata;
    logic [31:0] dq_out;
    logic        dq_oe;
    logic        wait_o;

    always #2 clk = ~clk;

    burst_read_engine #(.ADDR_W(20), .DATA_W(32)) dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_we    (cfg_we),
        .cfg_wdata (cfg_wdata),
        .cfg_rdata (cfg_rdata),
        .ce_n      (ce_n),
        .adv_n     (adv_n),
        .addr      (addr),
        .dq_out    (dq_out),
        .dq_oe     (dq_oe),
        .wait_o    (wait_o)
    );

    int    checks = 0;
    int    errors = 0;
    bit    finished = 1'b0;
    string scen = "R1";

    // reference model state
    bit          q_oe[$];
    bit          q_wt[$];
    logic [31:0] q_dq[$];
    string       q_tag[$];
    bit          e_oe = 1'b0;
    bit          e_wt = 1'b0;
    logic [31:0] e_dq = 32'h0;
    string       e_tag = "R1";
    bit          from_q = 1'b0;
    bit          async_on = 1'b0;
    logic [19:0] async_a = 20'h0;
    logic [15:0] e_cfg = 16'h9CC3;

    function automatic logic [31:0] word_at(logic [19:0] a);
        logic [15:0] f;
        f = a[15:0] ^ {12'h000, a[19:16]};
        return {f ^ 16'h5A5A, f};
    endfunction

    function automatic bit burst_allowed(logic [15:0] c);
        bit len_ok;
        len_ok = (c[2:0] == 3'd1) || (c[2:0] == 3'd2) || (c[2:0] == 3'd3);
        return !c[15] && !c[13] && !c[9] && c[7] && c[6] && len_ok;
    endfunction

    function automatic logic [15:0] mk_cfg(bit rm, logic [3:0] lat, bit early, logic [2:0] len);
        return {rm, 1'b0, lat, 1'b0, early, 2'b11, 3'b000, len};
    endfunction

    task automatic plan_burst(logic [15:0] c, logic [19:0] a);
        int lat;
        int n;
        lat = int'(c[12:10]) + 2;
        n   = 1 << int'(c[1:0]);
        for (int k = 0; k < lat; k++) begin
            q_oe.push_back(1'b0);
            q_wt.push_back(c[8] ? (k < lat - 1) : 1'b1);
            q_dq.push_back(32'h0);
            q_tag.push_back("R4");
        end
        for (int i = 0; i < n; i++) begin
            logic [19:0] m;
            logic [19:0] ad;
            m  = 20'(n - 1);
            ad = (a & ~m) | ((a + 20'(i)) & m);
            q_oe.push_back(1'b1);
            q_wt.push_back(1'b0);
            q_dq.push_back(word_at(ad));
            q_tag.push_back("R6");
        end
    endtask

    always @(posedge clk) begin
        if (!rst_n) begin
            q_oe.delete(); q_wt.delete(); q_dq.delete(); q_tag.delete();
            e_oe = 0; e_wt = 0; e_dq = 0; e_tag = "R1";
            from_q = 0; async_on = 0; e_cfg = 16'h9CC3;
        end else begin
            if (ce_n) begin
                q_oe.delete(); q_wt.delete(); q_dq.delete(); q_tag.delete();
                from_q = 0; async_on = 0;
                e_oe = 0; e_wt = 0; e_dq = 0; e_tag = "R9";
            end else begin
                if (!from_q && !adv_n) begin
                    if (burst_allowed(e_cfg)) begin
                        async_on = 0;
                        plan_burst(e_cfg, addr);
                    end else begin
                        async_on = 1;
                        async_a  = addr;
                    end
                end
                if (q_oe.size() > 0) begin
                    e_oe = q_oe.pop_front();
                    e_wt = q_wt.pop_front();
                    e_dq = q_dq.pop_front();
                    e_tag = q_tag.pop_front();
                    from_q = 1;
                end else begin
                    from_q = 0;
                    e_wt = 0;
                    if (async_on) begin
                        e_oe = 1; e_dq = word_at(async_a); e_tag = "R8";
                    end else begin
                        e_oe = 0; e_dq = 0; e_tag = "R5";
                    end
                end
            end
            if (cfg_we) e_cfg = cfg_wdata & 16'hBFC7;
        end
    end

    task automatic chk(logic [31:0] act, logic [31:0] exp, string tag, string what);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h at %0t", tag, what, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (!finished) begin
            chk(32'(dq_oe), 32'(e_oe), {e_tag, "/", scen}, "dq_oe");
            chk(dq_out, e_dq, {e_tag, "/R11/", scen}, "dq_out");
            chk(32'(wait_o), 32'(e_wt), {"R7/", scen}, "wait_o");
            chk(32'(cfg_rdata), 32'(e_cfg), {"R1/R2/", scen}, "cfg_rdata");
        end
    end

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr_cfg(logic [15:0] v);
        @(negedge clk);
        cfg_we = 1'b1; cfg_wdata = v;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic strobe(logic [19:0] a);
        @(negedge clk);
        ce_n = 1'b0; adv_n = 1'b0; addr = a;
        @(negedge clk);
        adv_n = 1'b1;
    endtask

    task automatic release_ce();
        @(negedge clk);
        ce_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL R1 watchdog: actual hung expected completion");
            finish_run();
        end
    end

    initial begin
        idle(3);
        rst_n = 1'b1;
        scen = "R1";
        idle(3);

        // R2: reserved bits masked
        scen = "R2";
        wr_cfg(16'hFFFF);
        idle(2);
        wr_cfg(16'h0000);
        idle(2);

        // R4: every latency code
        scen = "R4";
        for (int l = 0; l < 8; l++) begin
            wr_cfg(mk_cfg(0, 4'(l), 0, 3'd3));
            strobe(20'h00100 + 20'(l * 8));
            idle(l + 12);
        end

        // R5 and R3: every length code, reserved ones fall back to async
        for (int n = 0; n < 8; n++) begin
            scen = (n >= 1 && n <= 3) ? "R5" : "R3";
            wr_cfg(mk_cfg(0, 4'd0, 0, 3'(n)));
            strobe(20'h00203);
            idle(12);
            release_ce();
        end

        // R6: unaligned start wraps inside the group
        scen = "R6";
        wr_cfg(mk_cfg(0, 4'd1, 0, 3'd2));
        strobe(20'h01235);
        idle(10);
        wr_cfg(mk_cfg(0, 4'd2, 0, 3'd3));
        strobe(20'h3ABCF);
        idle(14);

        // R7: early wait release
        scen = "R7";
        wr_cfg(mk_cfg(0, 4'd0, 1, 3'd1));
        strobe(20'h00040);
        idle(6);
        wr_cfg(mk_cfg(0, 4'd7, 1, 3'd2));
        strobe(20'h00051);
        idle(16);

        // R3: other settings that disable bursts
        scen = "R3";
        wr_cfg(mk_cfg(1, 4'd1, 0, 3'd3));
        strobe(20'h00600); idle(5); release_ce();
        wr_cfg(mk_cfg(0, 4'd9, 0, 3'd3));
        strobe(20'h00610); idle(5); release_ce();
        wr_cfg(mk_cfg(0, 4'd1, 0, 3'd3) | 16'h0200);
        strobe(20'h00620); idle(5); release_ce();
        wr_cfg(mk_cfg(0, 4'd1, 0, 3'd3) & ~16'h0080);
        strobe(20'h00630); idle(5); release_ce();
        wr_cfg(mk_cfg(0, 4'd1, 0, 3'd3) & ~16'h0040);
        strobe(20'h00640); idle(5); release_ce();

        // R8: async hold and re-strobe
        scen = "R8";
        wr_cfg(mk_cfg(1, 4'd0, 0, 3'd3));
        strobe(20'h0ABCD);
        idle(4);
        strobe(20'h1F00E);
        idle(4);
        release_ce();

        // R9: abort during latency and during burst
        scen = "R9";
        wr_cfg(mk_cfg(0, 4'd5, 0, 3'd3));
        strobe(20'h00700);
        idle(3);
        release_ce();
        strobe(20'h00708);
        idle(9);
        release_ce();
        idle(2);

        // R10: stray strobes in latency and burst
        scen = "R10";
        wr_cfg(mk_cfg(0, 4'd2, 0, 3'd3));
        strobe(20'h00800);
        idle(2);
        strobe(20'h00900);
        idle(4);
        strobe(20'h00A00);
        idle(8);

        // R12: config write during an access
        scen = "R12";
        wr_cfg(mk_cfg(0, 4'd3, 0, 3'd3));
        strobe(20'h00B03);
        wr_cfg(mk_cfg(0, 4'd0, 1, 3'd1));
        idle(14);
        strobe(20'h00C01);
        idle(6);
        release_ce();

        idle(3);
        finish_run();
    end

endmodule